// File: doc/BRIEF.md
# Ping-Pong Fiducial Event Sequencer

This block sends a list of timed event codes after every start pulse, where the start pulse is the periodic fiducial of a timing system. A list entry holds an 8-bit event code and a tick count measured from the start pulse. The tick advances once per clock, nominally 8 ns. The block holds two such lists, called banks. One bank is armed and plays out when a start arrives. When its last entry has been sent, that bank is handed back to software and the other bank, loaded in the meantime, becomes the armed one. The output is one event code per clock toward the downstream stream multiplexer, with code 0 meaning "no event".

Software writes entries through a simple write port, and every write lands in the bank that is not armed or playing. The `activeBank` output tells software which bank that is. A start that arrives while a list is still playing is ignored and reported on `overrun`. If the downstream multiplexer reports busy when an event is due, that event is held back, `stall` pulses, and the event goes out on the first clock the multiplexer is free again.

Top module: `evseq_top`

## Requirements
- R1: After reset, `evCode` is 0, `activeBank` is 0, and `busy`, `overrun` and `stall` are all 0.
- R2: When `startPulse` is sampled high while `busy` is 0, `busy` rises on the next clock and the tick count restarts at 0. An entry with count c that is not held back by R3 or R8 drives its code onto `evCode` for exactly one clock, in the clock that follows the (c+1)-th rising edge after the edge that sampled the start. `evCode` is 0 in every clock in which no entry is sent. For example, an entry (code 1, count 0) appears one clock after the start is taken.
- R3: Entries play in address order starting at address 0, and at most one code is sent per tick. An entry whose count has already passed is sent on the next free tick. Several entries with the same count are therefore sent on consecutive ticks.
- R4: Playback ends at the first entry whose code is 0, or after address DEPTH-1 has been sent. One clock after the end is detected, `busy` falls.
- R5: When playback ends, `activeBank` toggles, so the next start plays the other bank.
- R6: A write with `wrEn` high stores `wrCode` and `wrCount` at `wrAddr` of the bank that `activeBank` does not select. A write made while a list plays does not change the list that is playing, and it is used by the later playback of the written bank.
- R7: A `startPulse` sampled while `busy` is 1 makes `overrun` high for exactly the next clock. It changes neither the events being sent nor their timing.
- R8: When `downBusy` is high in a clock where an entry is due, that entry is not sent. In the next clock `evCode` is 0 and `stall` is 1. The entry is sent in the first tick in which `downBusy` is low.
- R9: A bank that has not been written since reset, or since it last played, plays as an empty list when started. In that case `busy` is high for one clock, no event is sent, and `activeBank` toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Fiducial start request, one clock wide |
| wrEn | input | 1 | Write strobe into the inactive bank |
| wrAddr | input | $clog2(DEPTH) | Entry address of the write |
| wrCode | input | 8 | Event code to store (0 marks the end of the list) |
| wrCount | input | CNT_W | Tick count to store |
| downBusy | input | 1 | Downstream multiplexer cannot take an event this tick |
| evCode | output | 8 | Event code sent this tick, 0 when none |
| activeBank | output | 1 | Bank that is armed or playing |
| busy | output | 1 | A list is playing |
| overrun | output | 1 | A start was rejected in the previous clock |
| stall | output | 1 | A due event was held back in the previous clock |

## Verification
The bench builds the sequencer with DEPTH=8 and CNT_W=16. With these values a full bank can play out in a handful of clocks, which exercises the end-at-last-address case next to the end-at-terminator case, and it makes full tables cheap to load. The tick gaps of a few clocks are enough to create late entries, shared counts, overruns in the middle of a playback and held-back events. A behavioural per-clock model compares every output on every clock, and directed checks pin the exact clock of the swap, overrun and stall cases.

// File: rtl/evseq_pkg.sv
package evseq_pkg;
  localparam int CODE_W = 8;

  typedef enum logic {ST_IDLE = 1'b0, ST_PLAY = 1'b1} seqState_t;

  typedef struct packed {
    logic launch;
    logic run;
    logic emit;
  } seqStrobe_t;
endpackage

// File: rtl/evseq_datapath.sv
module evseq_datapath
  import evseq_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int CNT_W = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        st,
  input  logic              activeBank,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [CODE_W-1:0] wrCode,
  input  logic [CNT_W-1:0]  wrCount,
  output logic [CODE_W-1:0] curCode,
  output logic [CNT_W-1:0]  curCount,
  output logic [CNT_W-1:0]  tickNow,
  output logic              tableEnd,
  output logic [CODE_W-1:0] evCode
);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH);

  logic [PW-1:0]     ptrQ;
  logic [CNT_W-1:0]  tickQ;
  logic [CODE_W-1:0] evCodeQ;
  logic [CODE_W-1:0] rdCode  [2];
  logic [CNT_W-1:0]  rdCount [2];

  // One storage array per bank; writes only reach the bank not selected.
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [CODE_W-1:0] codeMem [DEPTH];
    logic [CNT_W-1:0]  cntMem  [DEPTH];
    logic              bankWr;

    assign bankWr = wrEn && (activeBank != 1'(b));

    always_ff @(posedge clk) begin
      if (bankWr) begin
        codeMem[wrAddr] <= wrCode;
        cntMem[wrAddr]  <= wrCount;
      end
    end

    assign rdCode[b]  = codeMem[ptrQ[AW-1:0]];
    assign rdCount[b] = cntMem[ptrQ[AW-1:0]];
  end

  assign curCode  = rdCode[activeBank];
  assign curCount = rdCount[activeBank];
  assign tickNow  = tickQ;
  assign tableEnd = (ptrQ == PTR_LAST);
  assign evCode   = evCodeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ    <= '0;
      tickQ   <= '0;
      evCodeQ <= '0;
    end else begin
      if (st.launch) begin
        ptrQ  <= '0;
        tickQ <= '0;
      end else begin
        if (st.emit) ptrQ <= ptrQ + 1'b1;
        if (st.run)  tickQ <= tickQ + 1'b1;
      end
      evCodeQ <= st.emit ? curCode : '0;
    end
  end

  AST_CODE_ONLY_WHEN_PLAYING: assert property (@(posedge clk) disable iff (!rstN)
    (evCodeQ != '0) |-> $past(st.run)); // R2

  AST_START_KEEPS_POINTER: assert property (@(posedge clk) disable iff (!rstN)
    st.run |=> (ptrQ >= $past(ptrQ))); // R7
endmodule

// File: rtl/evseq_ctrl.sv
module evseq_ctrl
  import evseq_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              wrEn,
  input  logic              downBusy,
  input  logic [CODE_W-1:0] curCode,
  input  logic [CNT_W-1:0]  curCount,
  input  logic [CNT_W-1:0]  tickNow,
  input  logic              tableEnd,
  output seqStrobe_t        st,
  output logic              activeBank,
  output logic              playing,
  output logic              overrun,
  output logic              stall
);
  seqState_t stateQ;
  logic      bankQ;
  logic [1:0] loadedQ;
  logic      overrunQ;
  logic      stallQ;
  logic      endNow;
  logic      due;
  logic      finish;

  assign endNow = !loadedQ[bankQ] || tableEnd || (curCode == '0);
  assign due    = (curCount <= tickNow);

  always_comb begin
    st.launch = (stateQ == ST_IDLE) && startPulse;
    st.run    = (stateQ == ST_PLAY);
    st.emit   = st.run && !endNow && due && !downBusy;
  end

  assign finish     = st.run && endNow;
  assign activeBank = bankQ;
  assign playing    = st.run;
  assign overrun    = overrunQ;
  assign stall      = stallQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      bankQ    <= 1'b0;
      loadedQ  <= 2'b00;
      overrunQ <= 1'b0;
      stallQ   <= 1'b0;
    end else begin
      if (st.launch)   stateQ <= ST_PLAY;
      else if (finish) stateQ <= ST_IDLE;
      if (finish) begin
        bankQ           <= ~bankQ;
        loadedQ[bankQ]  <= 1'b0;
      end
      if (wrEn) loadedQ[~bankQ] <= 1'b1;
      overrunQ <= st.run && startPulse;
      stallQ   <= st.run && !endNow && due && downBusy;
    end
  end

  AST_SWAP_ON_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(playing) |-> (bankQ != $past(bankQ))); // R5

  AST_LAUNCH_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(playing) |-> $past(startPulse)); // R2
endmodule

// File: rtl/evseq_top.sv
module evseq_top
  import evseq_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int CNT_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [CODE_W-1:0] wrCode,
  input  logic [CNT_W-1:0]  wrCount,
  input  logic              downBusy,
  output logic [CODE_W-1:0] evCode,
  output logic              activeBank,
  output logic              busy,
  output logic              overrun,
  output logic              stall
);
  seqStrobe_t        st;
  logic [CODE_W-1:0] curCode;
  logic [CNT_W-1:0]  curCount;
  logic [CNT_W-1:0]  tickNow;
  logic              tableEnd;

  evseq_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .wrEn(wrEn),
    .downBusy(downBusy), .curCode(curCode), .curCount(curCount),
    .tickNow(tickNow), .tableEnd(tableEnd), .st(st),
    .activeBank(activeBank), .playing(busy), .overrun(overrun), .stall(stall)
  );

  evseq_datapath #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .activeBank(activeBank),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrCode(wrCode), .wrCount(wrCount),
    .curCode(curCode), .curCount(curCount), .tickNow(tickNow),
    .tableEnd(tableEnd), .evCode(evCode)
  );

  AST_STALL_SENDS_NOTHING: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (evCode == '0)); // R8

  AST_BUSY_BLOCKS_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    $past(downBusy) |-> (evCode == '0)); // R8

  AST_OVERRUN_WHILE_PLAYING: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> $past(busy)); // R7
endmodule

// File: tb/evseq_top_tb_top.sv
module evseq_top_tb_top;
  localparam int DEPTH = 8;
  localparam int CNT_W = 16;
  localparam int AW = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startPulse = 1'b0;
  logic             wrEn = 1'b0;
  logic [AW-1:0]    wrAddr = '0;
  logic [7:0]       wrCode = '0;
  logic [CNT_W-1:0] wrCount = '0;
  logic             downBusy = 1'b0;
  logic [7:0]       evCode;
  logic             activeBank, busy, overrun, stall;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  evseq_top #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrCode(wrCode), .wrCount(wrCount), .downBusy(downBusy),
    .evCode(evCode), .activeBank(activeBank), .busy(busy),
    .overrun(overrun), .stall(stall)
  );

  // Behavioural reference model, advanced on each rising edge.
  int mCode [2][DEPTH];
  int mCnt  [2][DEPTH];
  bit mValid [2];
  int mBank, mTick, mPtr, mEv;
  bit mPlay, mOver, mStall;

  always @(posedge clk) begin
    int wb;
    if (!rstN) begin
      mBank = 0; mPlay = 0; mTick = 0; mPtr = 0; mEv = 0; mOver = 0; mStall = 0;
      mValid[0] = 0; mValid[1] = 0;
    end else begin
      wb = 1 - mBank;
      mEv = 0; mOver = 0; mStall = 0;
      if (mPlay) begin
        if (startPulse) mOver = 1;
        if (!mValid[mBank] || mPtr == DEPTH || mCode[mBank][mPtr] == 0) begin
          mPlay = 0; mValid[mBank] = 0; mBank = 1 - mBank;
        end else if (mCnt[mBank][mPtr] <= mTick) begin
          if (downBusy) mStall = 1;
          else begin mEv = mCode[mBank][mPtr]; mPtr++; end
        end
        mTick++;
      end else if (startPulse) begin
        mPlay = 1; mTick = 0; mPtr = 0;
      end
      if (wrEn) begin
        mCode[wb][wrAddr] = wrCode;
        mCnt[wb][wrAddr] = wrCount;
        mValid[wb] = 1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R2 model evCode", evCode, mEv);
      chk("R5 model activeBank", activeBank, mBank);
      chk("R4 model busy", busy, mPlay);
      chk("R7 model overrun", overrun, mOver);
      chk("R8 model stall", stall, mStall);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(int a, int c, int n);
    wrEn = 1; wrAddr = AW'(a); wrCode = 8'(c); wrCount = CNT_W'(n);
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic fire();
    startPulse = 1;
    @(negedge clk);
    startPulse = 0;
  endtask

  initial begin
    int exp1 [9];
    repeat (3) @(negedge clk);
    chk("R1 evCode", evCode, 0);
    chk("R1 activeBank", activeBank, 0);
    chk("R1 busy", busy, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 stall", stall, 0);
    rstN = 1;
    @(negedge clk);

    // Bank 1 load: late entry and shared counts (R3, R6).
    wr(0, 1, 0); wr(1, 3, 2); wr(2, 5, 2); wr(3, 7, 6);
    for (int i = 4; i < DEPTH; i++) wr(i, 0, 0);

    // Bank 0 never written: empty playback (R9).
    fire();
    chk("R9 busy one clock", busy, 1);
    @(negedge clk);
    chk("R9 busy dropped", busy, 0);
    chk("R9 bank swapped", activeBank, 1);
    chk("R9 no event", evCode, 0);

    wr(0, 9, 1);
    for (int i = 1; i < DEPTH; i++) wr(i, 0, 0);

    // Play bank 1 with an overrun and a write into bank 0 midway.
    exp1 = '{0, 1, 0, 3, 5, 0, 0, 7, 0};
    fire();
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk($sformatf("R2 R3 bank1 tick %0d", k), evCode, exp1[k]);
      if (k == 5) begin
        chk("R7 overrun pulse", overrun, 1);
        startPulse = 0;
      end
      if (k == 6) chk("R7 overrun one clock", overrun, 0);
      if (k == 2) begin wrEn = 1; wrAddr = 1; wrCode = 11; wrCount = 3; end
      if (k == 3) wrEn = 0;
      if (k == 4) startPulse = 1;
    end
    chk("R4 busy after terminator", busy, 0);
    chk("R5 bank after play", activeBank, 0);

    // Bank 0 now carries the midway write (R6).
    fire();
    @(negedge clk); chk("R6 t1", evCode, 0);
    @(negedge clk); chk("R6 t2", evCode, 9);
    @(negedge clk); chk("R6 t3", evCode, 0);
    @(negedge clk); chk("R6 written entry", evCode, 11);
    @(negedge clk); chk("R5 bank after bank0", activeBank, 1);

    // Stall table into bank 0, then bank 1 plays empty again (R9).
    wr(0, 4, 2); wr(1, 6, 2);
    for (int i = 2; i < DEPTH; i++) wr(i, 0, 0);
    fire();
    @(negedge clk);
    chk("R9 replayed bank empty", busy, 0);
    chk("R9 bank swapped again", activeBank, 0);

    // Full bank 1 for the end-of-depth case.
    for (int i = 0; i < DEPTH; i++) wr(i, 20 + i, i);

    // Bank 0 with busy downstream at the due tick (R8).
    fire();
    @(negedge clk);
    @(negedge clk);
    downBusy = 1;
    @(negedge clk);
    downBusy = 0;
    chk("R8 held code", evCode, 0);
    chk("R8 stall flag", stall, 1);
    @(negedge clk); chk("R8 sent after stall", evCode, 4);
    chk("R8 stall cleared", stall, 0);
    @(negedge clk); chk("R8 next entry", evCode, 6);
    @(negedge clk); chk("R4 busy after stall table", busy, 0);

    // Bank 1 full: ends after the last address (R4).
    fire();
    for (int k = 1; k <= DEPTH; k++) begin
      @(negedge clk);
      chk($sformatf("R4 full entry %0d", k), evCode, 19 + k);
    end
    chk("R4 busy at last entry", busy, 1);
    @(negedge clk);
    chk("R4 busy after depth", busy, 0);
    chk("R5 bank after full", activeBank, 0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule